// File: doc/BRIEF.md
# Overflow Interrupt Enable-Set Register

This block holds the overflow interrupt enables for a bank of performance counters in one 64-bit register. There are up to 31 event counters, each enabled at the bit whose index is the counter number. The cycle counter is enabled at bit 31. When the build includes it, a fixed-function instruction counter is enabled at bit 32. Every other bit is reserved: it reads as zero and no write changes it.

Software writes the register with set-only semantics. A 1 in a written bit turns that enable on, and a 0 leaves it as it was. Enables are turned off only through a separate clear strobe that carries its own 64-bit mask. If a set and a clear reach the same bit in the same cycle, the set wins.

Each enable gates the overflow flag of its own counter. The gated flags are ORed together into one interrupt line, which is registered, so it responds one clock after the flags and enables it is computed from.

Top module: `ovf_irq_enable_reg`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every enable reads 0 and `irq_o` is 0, whatever the write port carries during reset.
- R2: When `wr_en` is 1, a 1 in `wr_data` bit i sets enable i on the next clock edge, for event counter bits i in [0, NUM_EVT-1] and for the cycle counter bit at index 31.
- R3: When `wr_en` is 1, a 0 in a data bit leaves that enable unchanged, so writing all zeros changes no bit.
- R4: Bit 32 (fixed-function counter) behaves as a settable enable only when HAS_FIXED is 1. When HAS_FIXED is 0 it reads 0 and ignores both writes and overflow flags.
- R5: Bits 63..33, and event bits at index NUM_EVT..30, read 0 and are never set by a write.
- R6: When `clr_en` is 1, every implemented enable whose bit is 1 in `clr_mask` reads 0 after the next clock edge.
- R7: When a set and a clear address the same bit on the same edge, the bit ends up 1.
- R8: `irq_o` equals the OR over all bits of (enable AND `ovf_i`), taken at the previous clock edge, which is one cycle of latency.
- R9: An overflow flag on a reserved bit never raises `irq_o`, even after all ones have been written.
- R10: `rd_data` shows the current enables combinationally, with 1 meaning enabled. Under any mix of set and clear traffic the next value is (old AND NOT clear) OR set, restricted to the implemented bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Set-write strobe |
| wr_data | input | 64 | Set mask; a 1 sets the enable at that bit |
| clr_en | input | 1 | Clear strobe |
| clr_mask | input | 64 | Clear mask; a 1 clears the enable at that bit |
| ovf_i | input | 64 | Counter overflow flags, one per enable bit position |
| rd_data | output | 64 | Current enables; reserved bits read 0 |
| irq_o | output | 1 | Registered combined overflow interrupt |

## Verification
The bench builds two copies of the block side by side. The first uses the defaults (31 event counters with the fixed counter present). The second uses NUM_EVT = 5 and HAS_FIXED = 0, so bits 5 to 30 and bit 32 become reserved. Sweeping a single set bit and a single overflow flag across all 64 positions on both copies reaches every bit class: implemented event bits, the cycle bit, the optional bit in both its forms, and the reserved range. A long pseudo-random run of mixed sets, clears and overflow flags then tests the update rule, the set-over-clear priority and the one-cycle interrupt latency against a model that the bench computes arithmetically.

// File: rtl/ovf_ien_pkg.sv
package ovf_ien_pkg;
  localparam int REG_W   = 64;
  localparam int CYC_BIT = 31;
  localparam int FIX_BIT = 32;

  // Which register bits hold a real enable for a given build.
  function automatic logic [REG_W-1:0] impl_mask(input int num_evt, input bit has_fixed);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < REG_W; i++) begin
      if (i < num_evt && i < CYC_BIT) m[i] = 1'b1;
      if (i == CYC_BIT) m[i] = 1'b1;
      if (i == FIX_BIT && has_fixed) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Single-bit next state: set has priority over clear.
  function automatic logic bit_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // Gated overflow reduction.
  function automatic logic any_gated(input logic [REG_W-1:0] en, input logic [REG_W-1:0] ovf);
    return |(en & ovf);
  endfunction
endpackage

// File: rtl/ien_write_decode.sv
module ien_write_decode
  import ovf_ien_pkg::*;
#(
  parameter logic [REG_W-1:0] MASK = '1
) (
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_mask,
  output logic [REG_W-1:0] set_vec,
  output logic [REG_W-1:0] clr_vec
);
  // Strobes qualify the masks; reserved positions never see a set.
  always_comb begin
    set_vec = wr_en  ? (wr_data  & MASK) : '0;
    clr_vec = clr_en ? (clr_mask & MASK) : '0;
  end
endmodule

// File: rtl/ien_bit_cell.sv
module ien_bit_cell
  import ovf_ien_pkg::*;
#(
  parameter bit IMPL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_next;

  always_comb q_next = IMPL ? bit_next(q_o, set_i, clr_i) : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_next;
  end

  p_set_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && IMPL) |=> q_o);
  p_set_beats_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i && IMPL) |=> q_o);
  p_zero_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));
  p_clr_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  p_rsv_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !IMPL |=> !q_o);
endmodule

// File: rtl/ien_irq_reduce.sv
module ien_irq_reduce
  import ovf_ien_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] en_i,
  input  logic [REG_W-1:0] ovf_i,
  output logic             irq_o
);
  logic gated_any;

  always_comb gated_any = any_gated(en_i, ovf_i);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= gated_any;
  end

  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(en_i & ovf_i)) |=> irq_o);
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(en_i & ovf_i)) |=> !irq_o);
endmodule

// File: rtl/ovf_irq_enable_reg.sv
module ovf_irq_enable_reg
  import ovf_ien_pkg::*;
#(
  parameter int NUM_EVT   = 31,
  parameter bit HAS_FIXED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_mask,
  input  logic [REG_W-1:0] ovf_i,
  output logic [REG_W-1:0] rd_data,
  output logic             irq_o
);
  localparam logic [REG_W-1:0] MASK = impl_mask(NUM_EVT, HAS_FIXED);

  // Named internal events for checking.
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] en_q;

  ien_write_decode #(.MASK(MASK)) u_dec (
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .clr_en   (clr_en),
    .clr_mask (clr_mask),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec)
  );

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    ien_bit_cell #(.IMPL(MASK[i])) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[i]),
      .clr_i (clr_vec[i]),
      .q_o   (en_q[i])
    );
  end

  ien_irq_reduce u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (en_q),
    .ovf_i (ovf_i),
    .irq_o (irq_o)
  );

  always_comb rd_data = en_q;

  p_write_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || clr_en) |=> (rd_data == ((($past(rd_data) & ~$past(clr_en ? clr_mask : '0))
                                       | $past(wr_en ? wr_data : '0)) & MASK)));
  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clr_en) |=> $stable(rd_data));
endmodule

// File: tb/tb_ovf_irq_enable_reg.sv
`timescale 1ns/100ps
module tb_ovf_irq_enable_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic        clr_en = 1'b0;
  logic [63:0] clr_mask = '0;
  logic [63:0] ovf = '0;
  logic [63:0] rd_a, rd_b;
  logic        irq_a, irq_b;

  int n_cmp = 0;
  int n_bad = 0;
  logic [63:0] mdl_a = '0, mdl_b = '0;
  logic [63:0] msk_a, msk_b;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;

  ovf_irq_enable_reg dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .clr_en(clr_en), .clr_mask(clr_mask), .ovf_i(ovf),
    .rd_data(rd_a), .irq_o(irq_a));

  ovf_irq_enable_reg #(.NUM_EVT(5), .HAS_FIXED(1'b0)) dut_small (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .clr_en(clr_en), .clr_mask(clr_mask), .ovf_i(ovf),
    .rd_data(rd_b), .irq_o(irq_b));

  // Bench's own view of the implemented bits, built by bit class.
  function automatic logic [63:0] tb_mask(input int n, input bit fx);
    logic [63:0] m = '0;
    for (int k = 0; k < n; k++) m = m | (64'd1 << k);
    m = m | (64'd1 << 31);
    if (fx) m = m | (64'd1 << 32);
    return m;
  endfunction

  function automatic string tag_of(input int b);
    if (b < 32) return "R2";
    if (b == 32) return "R4";
    return "R5";
  endfunction

  task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Called at a falling edge: drive, cross one rising edge, check, go idle.
  task automatic step(input logic w, input logic [63:0] wd, input logic c,
                      input logic [63:0] cm, input logic [63:0] ov,
                      input string req_rd, input string req_irq);
    logic ea, eb;
    wr_en = w; wr_data = wd; clr_en = c; clr_mask = cm; ovf = ov;
    ea = (mdl_a & ov) != 0;
    eb = (mdl_b & ov) != 0;
    @(negedge clk);
    mdl_a = ((mdl_a & ~(c ? cm : 64'd0)) | (w ? wd : 64'd0)) & msk_a;
    mdl_b = ((mdl_b & ~(c ? cm : 64'd0)) | (w ? wd : 64'd0)) & msk_b;
    chk64({req_rd, " full"}, rd_a, mdl_a);
    chk64({req_rd, " small"}, rd_b, mdl_b);
    chk1({req_irq, " irq full"}, irq_a, ea);
    chk1({req_irq, " irq small"}, irq_b, eb);
    wr_en = 1'b0; clr_en = 1'b0; ovf = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    msk_a = tb_mask(31, 1'b1);
    msk_b = tb_mask(5, 1'b0);
    // R1: writes during reset are ignored
    wr_en = 1'b1; wr_data = '1; ovf = '1;
    repeat (3) @(negedge clk);
    chk64("R1 reset full", rd_a, 64'd0);
    chk64("R1 reset small", rd_b, 64'd0);
    chk1("R1 reset irq", irq_a | irq_b, 1'b0);
    wr_en = 1'b0; ovf = '0;
    rst_n = 1'b1;
    @(negedge clk);
    chk64("R1 after reset", rd_a | rd_b, 64'd0);

    // Single-bit set sweep, zero-write hold, clear
    for (int b = 0; b < 64; b++) begin
      step(1'b1, 64'd1 << b, 1'b0, '0, '0, tag_of(b), "R8");
      step(1'b1, 64'd0, 1'b0, '0, '0, "R3", "R8");
      step(1'b0, '0, 1'b1, 64'd1 << b, '0, "R6", "R8");
    end

    // Set everything, check reserved positions stay 0
    step(1'b1, '1, 1'b0, '0, '0, "R5", "R8");
    chk64("R4 small bit32", rd_b & (64'd1 << 32), 64'd0);
    chk64("R4 full bit32", rd_a & (64'd1 << 32), 64'd1 << 32);

    // Overflow sweep with all enables on: irq follows only implemented bits
    for (int b = 0; b < 64; b++) begin
      step(1'b0, '0, 1'b0, '0, 64'd1 << b, "R10", (b > 32) ? "R9" : "R8");
      step(1'b0, '0, 1'b0, '0, '0, "R10", "R8");
    end
    step(1'b0, '0, 1'b0, '0, ~msk_a, "R10", "R9");
    step(1'b0, '0, 1'b0, '0, '0, "R10", "R9");

    // Clear all, then overflow everywhere: no interrupt
    step(1'b0, '0, 1'b1, '1, '0, "R6", "R8");
    step(1'b0, '0, 1'b0, '0, '1, "R6", "R8");
    step(1'b0, '0, 1'b0, '0, '0, "R10", "R8");

    // Set and clear together
    step(1'b1, 64'h0000_0001_8000_0015, 1'b1, '1, '0, "R7", "R8");
    step(1'b1, '1, 1'b1, '1, '0, "R7", "R8");

    // Mixed pseudo-random traffic
    for (int t = 0; t < 400; t++) begin
      logic [63:0] d, m, o;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
      d = lfsr & {lfsr[31:0], lfsr[63:32]};
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
      m = lfsr | {lfsr[15:0], lfsr[63:16]};
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
      o = lfsr & {lfsr[7:0], lfsr[63:8]} & {lfsr[40:0], lfsr[63:41]};
      step(lfsr[3], d, lfsr[9], m, o, "R10", "R8");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule